// File: doc/BRIEF.md
# Serial Link PHY Bring-Up Sequencer

This block is a hardware state machine that takes a multi-speed serial storage PHY from reset to link-ready without software help. After a start request it drives a short program of byte writes over an 8-bit address/data register bus. The program depends on the selected link generation (1, 2 or 3) and on whether the transmit polarity is inverted. Between phases it polls status registers and waits a fixed interval between reads. It also holds a settling delay. All times are counted in pulses of a one-microsecond tick input. A poll that does not succeed in time ends the run with an error flag.

The program has eight parts, always in this order: a full reset, a speed override, a wait for the ready flags to drop, a compensation restart with a wait for its done flags, per-generation buffer settings, a partial reset release with a settling delay, spread-spectrum and PLL setup with a wait for the ready flags, and a finishing part. The finishing part removes the overrides, enables bit-lock detection and releases the last reset. The sequencer takes its configuration when a run starts. It reports busy while running and keeps done or error set until the next start.

Top module: `phy_bringup_seq`

## Requirements
- R1: After synchronous reset, busy, seq_done, seq_err, bus_wr and bus_rd are all 0.
- R2: A start request while idle raises busy on the next clock edge and clears seq_done and seq_err. On the edge after that, the first bus write is data 0x96 to address 0x00 (PLL, PLL-calibration, deserializer and macro resets: bits 1, 2, 4, 7).
- R3: The generation and polarity inputs are captured when a run starts. A start request while busy is ignored, and so are input changes during a run.
- R4: A generation select of 0 runs the generation-1 program. The speed word written to 0x12 carries code = generation−1 in both bits [1:0] and bits [4:3].
- R5: With polarity inversion set, the write 0x20→0x02 comes immediately after the reset write, and the final control write is 0x28. Without inversion, the first of these writes is skipped and the final control write is 0x08.
- R6: The first poll reads 0x01 until bits 0 and 1 are both 0. The other bits of the read value are ignored.
- R7: The compensation part writes 0x1E (generation 1) or 0x0F to 0x41. For generations 1 and 2 only, it then writes 0x33→0x42, 0x02→0x51 and 0x2A→0x47. It then writes 0x13→0x40 and polls 0x40 until bits 2 and 3 are both 1.
- R8: The buffer writes are 0x12→0x20, 0x64→0x21, 0x02→0x22, 0x00→0x23, 0x31→0x25 for generation 3; 0x01→0x20, 0x04→0x21, 0x02→0x22, 0x11→0x25 for generation 2; and 0x10→0x20, 0x03→0x21, 0x04→0x22 for generation 1.
- R9: After the write 0x10→0x00, at least SETTLE_US ticks pass before the next write, 0x03→0x56.
- R10: Spread spectrum is set with 0x03→0x56, 0x63→0x57, 0x00→0x58, 0xF1→0x59. Then 0x8D (generation 1) or 0xCD goes to 0x50. Then 0x01 is polled until bits 0 and 1 are both 1.
- R11: The finishing writes are 0x00→0x10, 0x00→0x72, 0x10→0x00, the control word→0x02, 0x61→0x86, 0x00→0x00. busy then falls, and seq_done is set and stays set, with no further bus access, until the next start.
- R12: Read data is sampled in the cycle after a bus_rd pulse. The address is held over that cycle. Successive reads of one poll are at least POLL_GAP_US ticks apart.
- R13: A poll read that fails when at least TIMEOUT_US ticks have passed since the poll began ends the run. seq_err is set, busy falls and no further bus access occurs. seq_err stays set until the next start.
- R14: bus_wr and bus_rd are never high together, a strobe is only issued while busy, and seq_done and seq_err are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| gen_sel | input | 2 | Link generation 1..3; 0 means 1 |
| tx_pol_inv | input | 1 | Invert transmit polarity |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bus_rdata | input | 8 | Register read data, valid the cycle after bus_rd |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Register write data |
| busy | output | 1 | Run in progress |
| seq_done | output | 1 | Last run completed |
| seq_err | output | 1 | Last run ended on a poll timeout |

## Verification
busy is due one edge after an accepted start. The reset write follows one edge later, and after that, writes come no faster than one per edge. A poll read's outcome is decided on the edge after its strobe. Because bus timing varies with poll outcomes and tick phase, the bench samples every strobe at the falling edge into a log stamped with a tick count, and compares the whole log with the expected sequence once busy falls. It checks gaps and the settling delay as tick differences within that log. Flags are checked at the falling edge after the start edge, again after the run, and again a dozen cycles later to confirm they hold.

// File: rtl/pbs_pkg.sv
// Shared types for the PHY bring-up sequencer.
// Assumes: one program step is executed per step index; data doubles as poll mask.
package pbs_pkg;

    localparam int STEP_IDX_W = 5;

    typedef enum logic [2:0] {
        K_WRITE    = 3'd0,
        K_SKIP     = 3'd1,
        K_POLL_CLR = 3'd2,
        K_POLL_SET = 3'd3,
        K_SETTLE   = 3'd4,
        K_END      = 3'd5
    } step_kind_e;

    typedef struct packed {
        step_kind_e  kind;
        logic [7:0]  addr;
        logic [7:0]  data;
    } step_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_EVAL = 2'd2,
        SQ_GAP  = 2'd3
    } sq_state_e;

    function automatic step_t mk_step(step_kind_e k, logic [7:0] a, logic [7:0] d);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.data = d;
        return s;
    endfunction

endpackage

// File: rtl/pbs_step_rom.sv
// Program store: maps a step index plus the latched generation and polarity
// to one step (write, skipped slot, poll, settling wait or end).
// Assumes: gen is already normalised to 1..3.
module pbs_step_rom
    import pbs_pkg::*;
(
    input  logic [STEP_IDX_W-1:0] idx,
    input  logic [1:0]            gen,
    input  logic                  pol,
    output step_t                 step
);

    logic       is_g1;
    logic       is_g3;
    logic [1:0] code;

    // Purpose: derive per-generation selectors used by the program table.
    always_comb begin
        is_g1 = (gen == 2'd1);
        is_g3 = (gen == 2'd3);
        code  = gen - 2'd1;
    end

    // Purpose: decode the current step from the index.
    always_comb begin
        step = mk_step(K_END, 8'h00, 8'h00);
        case (idx)
            // full reset, optional polarity, speed override
            5'd0:  step = mk_step(K_WRITE, 8'h00, 8'h96);
            5'd1:  step = pol ? mk_step(K_WRITE, 8'h02, 8'h20) : mk_step(K_SKIP, 8'h00, 8'h00);
            5'd2:  step = mk_step(K_WRITE, 8'h10, 8'h01);
            5'd3:  step = mk_step(K_WRITE, 8'h72, 8'h40);
            5'd4:  step = mk_step(K_WRITE, 8'h12, {3'b000, code, 1'b0, code});
            5'd5:  step = mk_step(K_POLL_CLR, 8'h01, 8'h03);
            // compensation
            5'd6:  step = mk_step(K_WRITE, 8'h41, is_g1 ? 8'h1E : 8'h0F);
            5'd7:  step = is_g3 ? mk_step(K_SKIP, 8'h00, 8'h00) : mk_step(K_WRITE, 8'h42, 8'h33);
            5'd8:  step = is_g3 ? mk_step(K_SKIP, 8'h00, 8'h00) : mk_step(K_WRITE, 8'h51, 8'h02);
            5'd9:  step = is_g3 ? mk_step(K_SKIP, 8'h00, 8'h00) : mk_step(K_WRITE, 8'h47, 8'h2A);
            5'd10: step = mk_step(K_WRITE, 8'h40, 8'h13);
            5'd11: step = mk_step(K_POLL_SET, 8'h40, 8'h0C);
            // buffer bank
            5'd12: step = mk_step(K_WRITE, 8'h20, is_g3 ? 8'h12 : (is_g1 ? 8'h10 : 8'h01));
            5'd13: step = mk_step(K_WRITE, 8'h21, is_g3 ? 8'h64 : (is_g1 ? 8'h03 : 8'h04));
            5'd14: step = mk_step(K_WRITE, 8'h22, is_g1 ? 8'h04 : 8'h02);
            5'd15: step = is_g3 ? mk_step(K_WRITE, 8'h23, 8'h00) : mk_step(K_SKIP, 8'h00, 8'h00);
            5'd16: step = is_g3 ? mk_step(K_WRITE, 8'h25, 8'h31)
                        : (is_g1 ? mk_step(K_SKIP, 8'h00, 8'h00) : mk_step(K_WRITE, 8'h25, 8'h11));
            // partial reset release and settle
            5'd17: step = mk_step(K_WRITE, 8'h00, 8'h10);
            5'd18: step = mk_step(K_SETTLE, 8'h00, 8'h00);
            // spread spectrum and PLL
            5'd19: step = mk_step(K_WRITE, 8'h56, 8'h03);
            5'd20: step = mk_step(K_WRITE, 8'h57, 8'h63);
            5'd21: step = mk_step(K_WRITE, 8'h58, 8'h00);
            5'd22: step = mk_step(K_WRITE, 8'h59, 8'hF1);
            5'd23: step = mk_step(K_WRITE, 8'h50, is_g1 ? 8'h8D : 8'hCD);
            5'd24: step = mk_step(K_POLL_SET, 8'h01, 8'h03);
            // finishing
            5'd25: step = mk_step(K_WRITE, 8'h10, 8'h00);
            5'd26: step = mk_step(K_WRITE, 8'h72, 8'h00);
            5'd27: step = mk_step(K_WRITE, 8'h00, 8'h10);
            5'd28: step = mk_step(K_WRITE, 8'h02, pol ? 8'h28 : 8'h08);
            5'd29: step = mk_step(K_WRITE, 8'h86, 8'h61);
            5'd30: step = mk_step(K_WRITE, 8'h00, 8'h00);
            default: step = mk_step(K_END, 8'h00, 8'h00);
        endcase
    end

endmodule

// File: rtl/pbs_tick_count.sv
// Saturating counter of microsecond ticks with synchronous clear.
// Assumes: clr wins over tick; the count holds at its all-ones value.
module pbs_tick_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    // Purpose: count ticks, clear on request, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick && (count != SAT)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/phy_bringup_seq.sv
// Top of the PHY bring-up sequencer. Walks the step program, issues one bus
// write per cycle, polls with a tick-timed gap, holds the settling delay and
// ends a poll with an error once its tick budget is spent.
// Assumes: bus_rdata is valid in the cycle after bus_rd; us_tick is one cycle wide.
module phy_bringup_seq
    import pbs_pkg::*;
#(
    parameter int POLL_GAP_US = 2000,
    parameter int TIMEOUT_US  = 100000,
    parameter int SETTLE_US   = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] gen_sel,
    input  logic       tx_pol_inv,
    input  logic       us_tick,
    input  logic [7:0] bus_rdata,
    output logic       bus_wr,
    output logic       bus_rd,
    output logic [7:0] bus_addr,
    output logic [7:0] bus_wdata,
    output logic       busy,
    output logic       seq_done,
    output logic       seq_err
);

    localparam int STEP_MAX = (TIMEOUT_US > SETTLE_US + 1) ? TIMEOUT_US : SETTLE_US + 1;
    localparam int STEP_CW  = $clog2(STEP_MAX + 2);
    localparam int GAP_CW   = $clog2(POLL_GAP_US + 2);
    localparam logic [STEP_CW-1:0] TMO_LIM    = STEP_CW'(TIMEOUT_US);
    localparam logic [STEP_CW-1:0] SETTLE_LIM = STEP_CW'(SETTLE_US + 1);
    localparam logic [GAP_CW-1:0]  GAP_LIM    = GAP_CW'(POLL_GAP_US);

    sq_state_e              state;
    logic [STEP_IDX_W-1:0]  idx;
    logic [1:0]             gen_q;
    logic                   pol_q;
    step_t                  cur;
    logic [STEP_CW-1:0]     step_us;
    logic [GAP_CW-1:0]      gap_us;
    logic                   is_poll;
    logic                   poll_met;
    logic                   settle_over;
    logic                   advance;
    logic                   step_clr;
    logic                   gap_clr;
    logic [7:0]             masked;

    pbs_step_rom u_rom (
        .idx  (idx),
        .gen  (gen_q),
        .pol  (pol_q),
        .step (cur)
    );

    pbs_tick_count #(.CW(STEP_CW)) u_step_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (step_clr),
        .tick  (us_tick),
        .count (step_us)
    );

    pbs_tick_count #(.CW(GAP_CW)) u_gap_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gap_clr),
        .tick  (us_tick),
        .count (gap_us)
    );

    // Purpose: judge the sampled read data against the current poll mask.
    always_comb begin
        masked  = bus_rdata & cur.data;
        is_poll = (cur.kind == K_POLL_CLR) || (cur.kind == K_POLL_SET);
        case (cur.kind)
            K_POLL_CLR: poll_met = (masked == 8'h00);
            K_POLL_SET: poll_met = (masked == cur.data);
            default:    poll_met = 1'b0;
        endcase
        settle_over = (step_us >= SETTLE_LIM);
    end

    // Purpose: decide when the step index moves and when the timers restart.
    always_comb begin
        advance = ((state == SQ_RUN) &&
                   ((cur.kind == K_WRITE) || (cur.kind == K_SKIP) ||
                    ((cur.kind == K_SETTLE) && settle_over))) ||
                  ((state == SQ_EVAL) && poll_met);
        step_clr = ((state == SQ_IDLE) && start) || advance;
        gap_clr  = (state == SQ_RUN) && is_poll;
    end

    // Purpose: sequencer state, step index, bus strobes and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            idx       <= '0;
            gen_q     <= 2'd1;
            pol_q     <= 1'b0;
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
            bus_addr  <= 8'h00;
            bus_wdata <= 8'h00;
            busy      <= 1'b0;
            seq_done  <= 1'b0;
            seq_err   <= 1'b0;
        end else begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            if (advance) begin
                idx <= idx + 1'b1;
            end
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        gen_q    <= (gen_sel == 2'd0) ? 2'd1 : gen_sel;
                        pol_q    <= tx_pol_inv;
                        idx      <= '0;
                        busy     <= 1'b1;
                        seq_done <= 1'b0;
                        seq_err  <= 1'b0;
                        state    <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    case (cur.kind)
                        K_WRITE: begin
                            bus_wr    <= 1'b1;
                            bus_addr  <= cur.addr;
                            bus_wdata <= cur.data;
                        end
                        K_POLL_CLR, K_POLL_SET: begin
                            bus_rd   <= 1'b1;
                            bus_addr <= cur.addr;
                            state    <= SQ_EVAL;
                        end
                        K_END: begin
                            busy     <= 1'b0;
                            seq_done <= 1'b1;
                            state    <= SQ_IDLE;
                        end
                        default: begin
                        end
                    endcase
                end
                SQ_EVAL: begin
                    if (poll_met) begin
                        state <= SQ_RUN;
                    end else if (step_us >= TMO_LIM) begin
                        busy    <= 1'b0;
                        seq_err <= 1'b1;
                        state   <= SQ_IDLE;
                    end else begin
                        state <= SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    if (gap_us >= GAP_LIM) begin
                        state <= SQ_RUN;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/phy_bringup_seq_chk.sv
// Property checker for the bring-up sequencer, attached by bind.
// Assumes: observes only the top-level ports.
module phy_bringup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       busy,
    input logic       seq_done,
    input logic       seq_err
);

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R14

    AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> busy); // R14

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_err)); // R14

    AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (bus_wr && (bus_addr == 8'h00) && (bus_wdata == 8'h96))); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !start) |=> seq_err); // R13

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !start) |=> seq_done); // R11

    AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> ($stable(bus_addr) && !bus_wr && !bus_rd)); // R12

endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .seq_done  (seq_done),
    .seq_err   (seq_err)
);

// File: tb/tb_phy_bringup_seq.sv
`timescale 1ns/1ps
module tb_phy_bringup_seq;

    localparam int GAP    = 3;
    localparam int TMO    = 40;
    localparam int SETTLE = 4;
    localparam int NEVER  = 255;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [1:0] gen_sel;
    logic       tx_pol_inv;
    logic       us_tick = 1'b0;
    logic [7:0] bus_rdata;
    logic       bus_wr, bus_rd, busy, seq_done, seq_err;
    logic [7:0] bus_addr, bus_wdata;

    always #2.5 clk = ~clk;

    phy_bringup_seq #(.POLL_GAP_US(GAP), .TIMEOUT_US(TMO), .SETTLE_US(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gen_sel(gen_sel),
        .tx_pol_inv(tx_pol_inv), .us_tick(us_tick), .bus_rdata(bus_rdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .seq_done(seq_done), .seq_err(seq_err)
    );

    int errors = 0;
    int checks = 0;

    // tick every other cycle
    always @(negedge clk) us_tick <= ~us_tick;
    int tick_total = 0;
    always @(posedge clk) if (us_tick) tick_total <= tick_total + 1;

    // PHY model state
    int rd_a, rd_b, rd_c, need_a, need_b, need_c;
    bit seen50;
    logic [7:0] noise;

    always_comb begin
        if (bus_addr == 8'h01) begin
            if (!seen50) bus_rdata = (rd_a < need_a) ? (noise | 8'h03) : (noise & 8'hFC);
            else         bus_rdata = (rd_b < need_b) ? ((noise & 8'hFC) | 8'h02) : (noise | 8'h03);
        end else if (bus_addr == 8'h40) begin
            bus_rdata = (rd_c < need_c) ? ((noise & 8'hF3) | 8'h04) : (noise | 8'h0C);
        end else begin
            bus_rdata = 8'h00;
        end
    end

    // bus log
    logic [7:0] log_a [0:63];
    logic [7:0] log_d [0:63];
    int         log_t [0:63];
    int n_wr, bad_rd, gap_viol, strobe_idle;
    int prev_rd_t, prev_rd_n;
    logic [7:0] prev_rd_addr;
    bit prev_rd_v;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((bus_wr || bus_rd) && !busy) strobe_idle++;
            if (bus_wr) begin
                if (n_wr < 64) begin
                    log_a[n_wr] = bus_addr;
                    log_d[n_wr] = bus_wdata;
                    log_t[n_wr] = tick_total;
                end
                n_wr++;
                if (bus_addr == 8'h50) seen50 = 1'b1;
            end
            if (bus_rd) begin
                if (bus_addr == 8'h01) begin
                    if (seen50) rd_b++; else rd_a++;
                end else if (bus_addr == 8'h40) rd_c++;
                else bad_rd++;
                if (prev_rd_v && prev_rd_addr == bus_addr && prev_rd_n == n_wr &&
                    (tick_total - prev_rd_t) < GAP) gap_viol++;
                prev_rd_v = 1'b1;
                prev_rd_addr = bus_addr;
                prev_rd_t = tick_total;
                prev_rd_n = n_wr;
            end
        end
    end

    // expected sequence
    logic [7:0] exp_a [0:63];
    logic [7:0] exp_d [0:63];
    int en, cut_a, cut_c, cut_b;

    task automatic push(input logic [7:0] a, input logic [7:0] d);
        exp_a[en] = a;
        exp_d[en] = d;
        en++;
    endtask

    task automatic build_exp(input int g, input bit p);
        int gn;
        logic [7:0] c;
        gn = (g == 0) ? 1 : g;
        c = 8'(gn - 1);
        en = 0;
        push(8'h00, 8'h96);
        if (p) push(8'h02, 8'h20);
        push(8'h10, 8'h01);
        push(8'h72, 8'h40);
        push(8'h12, (c << 3) | c);
        cut_a = en;
        push(8'h41, (gn == 1) ? 8'h1E : 8'h0F);
        if (gn != 3) begin
            push(8'h42, 8'h33); push(8'h51, 8'h02); push(8'h47, 8'h2A);
        end
        push(8'h40, 8'h13);
        cut_c = en;
        if (gn == 3) begin
            push(8'h20, 8'h12); push(8'h21, 8'h64); push(8'h22, 8'h02);
            push(8'h23, 8'h00); push(8'h25, 8'h31);
        end else if (gn == 2) begin
            push(8'h20, 8'h01); push(8'h21, 8'h04); push(8'h22, 8'h02); push(8'h25, 8'h11);
        end else begin
            push(8'h20, 8'h10); push(8'h21, 8'h03); push(8'h22, 8'h04);
        end
        push(8'h00, 8'h10);
        push(8'h56, 8'h03); push(8'h57, 8'h63); push(8'h58, 8'h00); push(8'h59, 8'hF1);
        push(8'h50, (gn == 1) ? 8'h8D : 8'hCD);
        cut_b = en;
        push(8'h10, 8'h00); push(8'h72, 8'h00); push(8'h00, 8'h10);
        push(8'h02, p ? 8'h28 : 8'h08);
        push(8'h86, 8'h61); push(8'h00, 8'h00);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic run_case(input int g, input bit p, input int na, input int nc, input int nb,
                            input logic [7:0] nz, input bit mid, input string req);
        bit err_exp;
        int exp_len, cyc, mism, first_bad, si, n_end;
        @(negedge clk);
        rd_a = 0; rd_b = 0; rd_c = 0; seen50 = 0;
        need_a = na; need_b = nb; need_c = nc; noise = nz;
        n_wr = 0; bad_rd = 0; gap_viol = 0; strobe_idle = 0; prev_rd_v = 0;
        build_exp(g, p);
        err_exp = (na == NEVER) || (nc == NEVER) || (nb == NEVER);
        exp_len = (na == NEVER) ? cut_a : (nc == NEVER) ? cut_c : (nb == NEVER) ? cut_b : en;
        gen_sel = 2'(g); tx_pol_inv = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !seq_done && !seq_err, "R2", "start accepted flags", {busy, seq_done, seq_err}, 3'b100);
        if (mid) begin
            repeat (6) @(negedge clk);
            gen_sel = 2'(g == 3 ? 1 : 3); tx_pol_inv = ~p; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R3", "busy after ignored start", busy, 1);
        end
        cyc = 0;
        while (busy && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 20000, req, "run ended", cyc, 0);
        chk(seq_err == err_exp && seq_done == !err_exp, err_exp ? "R13" : "R11",
            "done/err", {seq_done, seq_err}, {!err_exp, err_exp});
        chk(n_wr == exp_len, req, "write count", n_wr, exp_len);
        mism = 0; first_bad = -1;
        for (int i = 0; i < exp_len && i < n_wr && i < 64; i++) begin
            if (log_a[i] != exp_a[i] || log_d[i] != exp_d[i]) begin
                if (first_bad < 0) first_bad = i;
                mism++;
            end
        end
        if (first_bad >= 0)
            chk(1'b0, req, $sformatf("write %0d addr/data", first_bad),
                {log_a[first_bad], log_d[first_bad]}, {exp_a[first_bad], exp_d[first_bad]});
        else
            chk(1'b1, req, "sequence", 0, 0);
        chk(gap_viol == 0, "R12", "poll gap violations", gap_viol, 0);
        chk(bad_rd == 0, "R6", "reads of unexpected address", bad_rd, 0);
        chk(strobe_idle == 0, "R14", "strobes while idle", strobe_idle, 0);
        if (!err_exp) begin
            si = p ? 1 : 0;
            si = cut_c + ((g == 3) ? 5 : (g == 2) ? 4 : 3);
            chk(si + 1 < n_wr && log_a[si + 1] == 8'h56 &&
                (log_t[si + 1] - log_t[si]) >= SETTLE, "R9", "settle ticks",
                log_t[si + 1] - log_t[si], SETTLE);
        end
        n_end = n_wr;
        repeat (12) @(negedge clk);
        chk(n_wr == n_end && seq_err == err_exp && seq_done == !err_exp && !busy,
            err_exp ? "R13" : "R11", "flags held, bus quiet", n_wr, n_end);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; gen_sel = 2'd1; tx_pol_inv = 1'b0;
        need_a = 1; need_b = 1; need_c = 1; noise = 8'h00;
        rd_a = 0; rd_b = 0; rd_c = 0; seen50 = 0;
        n_wr = 0; bad_rd = 0; gap_viol = 0; strobe_idle = 0; prev_rd_v = 0;
        repeat (4) @(negedge clk);
        chk(!busy && !seq_done && !seq_err && !bus_wr && !bus_rd, "R1", "reset outputs",
            {busy, seq_done, seq_err, bus_wr, bus_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !seq_done && !seq_err, "R1", "idle after reset", {busy, seq_done, seq_err}, 0);

        run_case(3, 1'b1, 1, 1, 1, 8'h00, 1'b0, "R5/R8 gen3 inverted");
        run_case(2, 1'b0, 3, 2, 4, 8'hF0, 1'b0, "R6/R8 gen2 retries");
        run_case(1, 1'b1, 2, 3, 2, 8'hA0, 1'b0, "R7/R10 gen1");
        run_case(0, 1'b0, 1, 1, 1, 8'h50, 1'b0, "R4 gen0 as gen1");
        run_case(2, 1'b0, NEVER, 1, 1, 8'h30, 1'b0, "R13 first poll timeout");
        run_case(3, 1'b1, 1, NEVER, 1, 8'hC0, 1'b0, "R7/R13 compensation timeout");
        run_case(1, 1'b0, 1, 1, NEVER, 8'h80, 1'b0, "R10/R13 ready timeout");
        run_case(3, 1'b0, 2, 1, 2, 8'h10, 1'b1, "R3 start while busy");
        for (int k = 0; k < 10; k++) begin
            run_case(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(1, 6)), int'($urandom_range(1, 6)),
                     int'($urandom_range(1, 6)), 8'($urandom_range(0, 255)) & 8'hF0,
                     1'($urandom_range(0, 1)), "R8 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule